// File: doc/BRIEF.md
# Split-Byte Sample Output Stage

This block sits between a 14-bit data converter and a narrow 8-bit output bus. Every converter result is shown on the bus as two consecutive bytes: the upper eight result bits first, then the remaining six bits packed toward the top of the bus with the two spare positions held at zero. A companion flag tells the receiver whether the byte currently on the bus is the upper or the lower half of a sample.

The bus advances by one byte on each tick of the converter clock enable. A byte-phase flag that alternates on every tick lets a sample enter only on the ticks that begin a new sample slot. A delay chain makes the upper byte of a sample appear a fixed number of ticks after it was taken. An active-low enable input is passed out as an active-high drive enable for the pad tri-state. The bus contents and the sample flow are not affected by it, so a receiver that releases the bus for a while finds the stream still in step when it returns.

Top module: `byte_out_mux`

## Requirements
- R1: While reset is asserted, and after its release until the first clock-enable tick, `bus_q` is 0 and `hi_byte` is 0; the pipeline is empty, and the first tick after reset presents an upper byte.
- R2: `bus_q` and `hi_byte` change only on clock edges where `clk_en` is 1; `hi_byte` inverts on every such tick.
- R3: On an upper-byte tick `hi_byte` is 1 and `bus_q[7:0]` equals sample bits 13 down to 6.
- R4: On the tick after an upper byte, `hi_byte` is 0, `bus_q[7:2]` equals bits 5 down to 0 of the same sample and `bus_q[1:0]` is 0.
- R5: A sample taken on tick k appears as the upper byte after tick k+2, the third tick counting the taking tick. Cycles with `clk_en` at 0 between these ticks do not count.
- R6: A sample is taken only when `smp_valid` is 1 on a tick whose update is an upper byte (ticks 0, 2, 4, ... after reset). `smp_valid` on any other tick, or with `clk_en` at 0, is ignored.
- R7: A slot in which no sample was taken shows 0 in both its upper and lower byte.
- R8: `bus_oe` equals the inverse of `oe_n` at all times. `oe_n` has no effect on `bus_q`, `hi_byte` or the sample flow.
- R9: Samples taken on every upper-byte tick stream out with no gap and in order, each as an upper byte followed by its lower byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clk_en | input | 1 | Converter clock enable; one tick per bus byte |
| smp_valid | input | 1 | Sample on `smp_data` is offered this tick |
| smp_data | input | 14 | Converter result |
| oe_n | input | 1 | Active-low output enable |
| bus_q | output | 8 | Byte presented on the output bus |
| bus_oe | output | 1 | Active-high pad drive enable |
| hi_byte | output | 1 | 1 when `bus_q` holds an upper byte |

## Verification
The enable input and a byte update can fall in the same cycle. The bench flips `oe_n` on the very ticks that load an upper byte and then a lower byte of a streamed sample. It judges the result by checking that `bus_oe` follows the pin at once while `bus_q` and `hi_byte` carry the byte the latency rule predicts. A sample offer can also coincide with a lower-byte tick. That case is provoked with data that would be visible if it were taken, and it is judged by the zero bytes of the following slots.

// File: rtl/byte_out_pkg.sv
package byte_out_pkg;

  // Which half of a sample the next bus update carries
  typedef enum logic {
    PH_LO = 1'b0,
    PH_HI = 1'b1
  } byte_ph_e;

endpackage

// File: rtl/byte_out_phase.sv
module byte_out_phase
  import byte_out_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tick,
  output byte_ph_e ph_nxt
);

  byte_ph_e ph_q;
  byte_ph_e ph_d;

  always_comb begin
    ph_d = ph_q;
    if (tick) begin
      ph_d = (ph_q == PH_HI) ? PH_LO : PH_HI;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= PH_HI;
    end else begin
      ph_q <= ph_d;
    end
  end

  assign ph_nxt = ph_q;

endmodule

// File: rtl/byte_out_delay.sv
module byte_out_delay #(
  parameter int W     = 14,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         in_vld,
  input  logic [W-1:0] in_dat,
  output logic         out_vld,
  output logic [W-1:0] out_dat
);

  logic [DEPTH-1:0] vld_q;
  logic [DEPTH-1:0] vld_d;
  logic [W-1:0]     dat_q [DEPTH];
  logic [W-1:0]     dat_d [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    if (i == 0) begin : g_head
      always_comb begin
        vld_d[i] = vld_q[i];
        dat_d[i] = dat_q[i];
        if (tick) begin
          vld_d[i] = in_vld;
          dat_d[i] = in_vld ? in_dat : '0;
        end
      end
    end else begin : g_body
      always_comb begin
        vld_d[i] = vld_q[i];
        dat_d[i] = dat_q[i];
        if (tick) begin
          vld_d[i] = vld_q[i-1];
          dat_d[i] = dat_q[i-1];
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q[i] <= 1'b0;
        dat_q[i] <= '0;
      end else begin
        vld_q[i] <= vld_d[i];
        dat_q[i] <= dat_d[i];
      end
    end
  end

  assign out_vld = vld_q[DEPTH-1];
  assign out_dat = dat_q[DEPTH-1];

endmodule

// File: rtl/byte_out_sel.sv
module byte_out_sel
  import byte_out_pkg::*;
#(
  parameter int SMP_W = 14,
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  byte_ph_e         ph,
  input  logic             word_vld,
  input  logic [SMP_W-1:0] word_dat,
  output logic [BUS_W-1:0] bus_q,
  output logic             hi_byte
);

  localparam int LO_W  = SMP_W - BUS_W;
  localparam int PAD_W = BUS_W - LO_W;

  logic [SMP_W-1:0] hold_q;
  logic [SMP_W-1:0] hold_d;
  logic [BUS_W-1:0] bus_d;
  logic             hi_d;
  logic [BUS_W-1:0] lo_word;

  // Lower part goes to the top of the bus, spare bits forced low
  if (PAD_W > 0) begin : g_pad
    assign lo_word = {hold_q[LO_W-1:0], {PAD_W{1'b0}}};
  end else begin : g_nopad
    assign lo_word = hold_q[LO_W-1:0];
  end

  always_comb begin
    hold_d = hold_q;
    bus_d  = bus_q;
    hi_d   = hi_byte;
    if (tick) begin
      if (ph == PH_HI) begin
        hold_d = word_vld ? word_dat : '0;
        bus_d  = hold_d[SMP_W-1 -: BUS_W];
        hi_d   = 1'b1;
      end else begin
        bus_d  = lo_word;
        hi_d   = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= '0;
      bus_q   <= '0;
      hi_byte <= 1'b0;
    end else begin
      hold_q  <= hold_d;
      bus_q   <= bus_d;
      hi_byte <= hi_d;
    end
  end

endmodule

// File: rtl/byte_out_mux.sv
module byte_out_mux
  import byte_out_pkg::*;
#(
  parameter int SMP_W = 14,
  parameter int BUS_W = 8,
  parameter int LAT   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_en,
  input  logic             smp_valid,
  input  logic [SMP_W-1:0] smp_data,
  input  logic             oe_n,
  output logic [BUS_W-1:0] bus_q,
  output logic             bus_oe,
  output logic             hi_byte
);

  // Stages ahead of the output register; must be even (LAT odd)
  localparam int DLY_N = LAT - 1;
  localparam int PAD_W = 2 * BUS_W - SMP_W;

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  byte_ph_e         ph_nxt;
  logic             take;
  logic             dly_vld;
  logic [SMP_W-1:0] dly_dat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  byte_out_phase u_phase (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .tick   (clk_en),
    .ph_nxt (ph_nxt)
  );

  // Offers are taken only at the start of a sample slot
  assign take = smp_valid && (ph_nxt == PH_HI);

  byte_out_delay #(
    .W     (SMP_W),
    .DEPTH (DLY_N)
  ) u_delay (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .tick    (clk_en),
    .in_vld  (take),
    .in_dat  (smp_data),
    .out_vld (dly_vld),
    .out_dat (dly_dat)
  );

  byte_out_sel #(
    .SMP_W (SMP_W),
    .BUS_W (BUS_W)
  ) u_sel (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .tick     (clk_en),
    .ph       (ph_nxt),
    .word_vld (dly_vld),
    .word_dat (dly_dat),
    .bus_q    (bus_q),
    .hi_byte  (hi_byte)
  );

  assign bus_oe = ~oe_n;

  // R2
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !clk_en |=> ($stable(bus_q) && $stable(hi_byte)));

  // R2
  byte_alt_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    clk_en |=> (hi_byte != $past(hi_byte)));

  // R4
  pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !hi_byte |-> (bus_q[PAD_W-1:0] == '0));

  // R6
  slot_align_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (clk_en && dly_vld) |-> (ph_nxt == PH_HI));

endmodule

// File: tb/byte_out_mux_bench.sv
`timescale 1ns/1ps
module byte_out_mux_bench;

  logic        clk;
  logic        rst_n;
  logic        clk_en;
  logic        smp_valid;
  logic [13:0] smp_data;
  logic        oe_n;
  logic [7:0]  bus_q;
  logic        bus_oe;
  logic        hi_byte;

  int n_chk;
  int n_bad;

  byte_out_mux u_byte_out_mux (
    .clk       (clk),
    .rst_n     (rst_n),
    .clk_en    (clk_en),
    .smp_valid (smp_valid),
    .smp_data  (smp_data),
    .oe_n      (oe_n),
    .bus_q     (bus_q),
    .bus_oe    (bus_oe),
    .hi_byte   (hi_byte)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [7:0] hi_of(input logic [13:0] d);
    return d[13:6];
  endfunction

  function automatic logic [7:0] lo_of(input logic [13:0] d);
    return {d[5:0], 2'b00};
  endfunction

  task automatic chk(input string tag, input logic [7:0] got_b, input logic [7:0] exp_b,
                     input logic got_h, input logic exp_h);
    n_chk++;
    if (got_b !== exp_b || got_h !== exp_h) begin
      n_bad++;
      $display("FAIL %s: bus=%02h hi=%0b expected bus=%02h hi=%0b", tag, got_b, got_h, exp_b, exp_h);
    end
  endtask

  task automatic chk_oe(input string tag, input logic exp_oe);
    n_chk++;
    if (bus_oe !== exp_oe) begin
      n_bad++;
      $display("FAIL %s: bus_oe=%0b expected %0b", tag, bus_oe, exp_oe);
    end
  endtask

  // Drive inputs just after an edge, let one edge pass, then settle
  task automatic step(input logic en, input logic v, input logic [13:0] d);
    clk_en    = en;
    smp_valid = v;
    smp_data  = d;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    clk_en    = 1'b0;
    smp_valid = 1'b0;
    smp_data  = '0;
    rst_n     = 1'b0;
    #1;
    chk("R1 reset asserted", bus_q, 8'h00, hi_byte, 1'b0);
    repeat (2) step(1'b1, 1'b1, 14'h3FFF);
    rst_n = 1'b1;
    repeat (3) step(1'b0, 1'b1, 14'h3FFF);
    chk("R1 after release", bus_q, 8'h00, hi_byte, 1'b0);
  endtask

  task automatic t_single();
    logic [13:0] s = 14'h2A5C;
    do_reset();
    step(1'b1, 1'b1, s);
    chk("R1 R7 first tick empty upper", bus_q, 8'h00, hi_byte, 1'b1);
    step(1'b1, 1'b0, 14'h0);
    chk("R7 empty lower", bus_q, 8'h00, hi_byte, 1'b0);
    step(1'b1, 1'b0, 14'h0);
    chk("R3 R5 upper byte", bus_q, hi_of(s), hi_byte, 1'b1);
    step(1'b1, 1'b0, 14'h0);
    chk("R4 lower byte", bus_q, lo_of(s), hi_byte, 1'b0);
    step(1'b1, 1'b0, 14'h0);
    chk("R7 next slot empty", bus_q, 8'h00, hi_byte, 1'b1);
  endtask

  task automatic t_gaps();
    logic [13:0] s = 14'h1F03;
    do_reset();
    step(1'b1, 1'b1, s);
    step(1'b0, 1'b1, 14'h3AAA);
    step(1'b0, 1'b1, 14'h3AAA);
    chk("R2 held without enable", bus_q, 8'h00, hi_byte, 1'b1);
    step(1'b1, 1'b1, 14'h3AAA);
    chk("R6 lower tick offer", bus_q, 8'h00, hi_byte, 1'b0);
    step(1'b0, 1'b0, 14'h0);
    step(1'b1, 1'b0, 14'h0);
    chk("R5 latency across gaps", bus_q, hi_of(s), hi_byte, 1'b1);
    step(1'b0, 1'b0, 14'h0);
    chk("R2 hold upper", bus_q, hi_of(s), hi_byte, 1'b1);
    step(1'b1, 1'b0, 14'h0);
    chk("R4 lower after gap", bus_q, lo_of(s), hi_byte, 1'b0);
    step(1'b1, 1'b0, 14'h0);
    chk("R6 ignored offer gives empty", bus_q, 8'h00, hi_byte, 1'b1);
    step(1'b1, 1'b0, 14'h0);
    chk("R6 ignored offer lower", bus_q, 8'h00, hi_byte, 1'b0);
  endtask

  task automatic t_lowphase();
    do_reset();
    step(1'b1, 1'b0, 14'h0);
    step(1'b1, 1'b1, 14'h3FFF);
    step(1'b1, 1'b0, 14'h0);
    chk("R6 slot after low offer", bus_q, 8'h00, hi_byte, 1'b1);
    step(1'b1, 1'b0, 14'h0);
    chk("R6 low offer not shown", bus_q, 8'h00, hi_byte, 1'b0);
    step(1'b1, 1'b0, 14'h0);
    chk("R6 later upper empty", bus_q, 8'h00, hi_byte, 1'b1);
  endtask

  task automatic t_stream();
    logic [13:0] s [4];
    s[0] = 14'h0001; s[1] = 14'h3FFF; s[2] = 14'h2000; s[3] = 14'h15A7;
    do_reset();
    for (int i = 0; i < 4; i++) begin
      step(1'b1, 1'b1, s[i]);
      step(1'b1, 1'b0, 14'h0);
    end
    // Ticks so far: 8; sample i emerged after ticks 2i+2, 2i+3
    // s[0..2] already shown; check the last one and re-run the flow for the rest
    do_reset();
    step(1'b1, 1'b1, s[0]);
    step(1'b1, 1'b0, 14'h0);
    for (int i = 1; i < 4; i++) begin
      step(1'b1, 1'b1, s[i]);
      chk("R9 stream upper", bus_q, hi_of(s[i-1]), hi_byte, 1'b1);
      step(1'b1, 1'b0, 14'h0);
      chk("R9 stream lower", bus_q, lo_of(s[i-1]), hi_byte, 1'b0);
    end
    step(1'b1, 1'b0, 14'h0);
    chk("R9 stream last upper", bus_q, hi_of(s[3]), hi_byte, 1'b1);
    step(1'b1, 1'b0, 14'h0);
    chk("R9 stream last lower", bus_q, lo_of(s[3]), hi_byte, 1'b0);
  endtask

  task automatic t_oe();
    logic [13:0] s = 14'h0ABC;
    do_reset();
    oe_n = 1'b0;
    #1;
    chk_oe("R8 enabled", 1'b1);
    step(1'b1, 1'b1, s);
    step(1'b1, 1'b0, 14'h0);
    oe_n = 1'b1;
    step(1'b1, 1'b0, 14'h0);
    chk_oe("R8 disabled on upper tick", 1'b0);
    chk("R8 data flows while disabled", bus_q, hi_of(s), hi_byte, 1'b1);
    oe_n = 1'b0;
    step(1'b1, 1'b0, 14'h0);
    chk_oe("R8 re-enabled on lower tick", 1'b1);
    chk("R8 lower after re-enable", bus_q, lo_of(s), hi_byte, 1'b0);
  endtask

  initial begin
    n_chk     = 0;
    n_bad     = 0;
    rst_n     = 1'b0;
    clk_en    = 1'b0;
    smp_valid = 1'b0;
    smp_data  = '0;
    oe_n      = 1'b0;
    @(posedge clk);
    #1;
    t_single();
    t_gaps();
    t_lowphase();
    t_stream();
    t_oe();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 20000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule